// File: doc/BRIEF.md
# Nibble Data-Pointer Memory Unit

This block is the data-memory side of a small 4-bit processor core. It owns a two-part data pointer (a high page part and a low offset part) and a nibble-wide scratch RAM addressed by their concatenation. The core's decoder sends it one operation per clock together with a small immediate and the current accumulator value. The block then loads, stores or swaps the addressed nibble against the accumulator, adjusts that nibble in place (step up or down, force one bit), walks the pointer after a swap, or compares the offset part with the immediate.

Results come back registered. `acc_out` carries the nibble that the accumulator must take, and `acc_take` marks the cycle in which it is new. `zf` is the zero flag. The pointer is visible on `ptr_hi` and `ptr_lo` so that the core can use the offset as a port address. A swap that moves the pointer derives the zero flag from the pointer result and not from the data.

Top module: `dpm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `acc_out`, `acc_take`, `zf`, `ptr_hi` and `ptr_lo` to zero. RAM contents are not cleared.
- R2: With `op_valid` high, op code 2 (store) writes `acc_in` into M(ptr). Op code 1 (load) presents M(ptr) on `acc_out` with `acc_take`=1. Neither one changes `zf` or the pointer.
- R3: Op code 3 (swap) presents the old M(ptr) on `acc_out` with `acc_take`=1, writes `acc_in` into M(ptr), and leaves the pointer and `zf` unchanged. Every swap variant (codes 3 to 6) reads and writes the address held before any pointer change.
- R4: Op code 4 swaps as in R3, then sets `ptr_lo` to `ptr_lo`+1 modulo 16. `zf` becomes 1 exactly when the new `ptr_lo` is 0.
- R5: Op code 5 swaps as in R3, then sets `ptr_lo` to `ptr_lo`-1 modulo 16. `zf` becomes 1 exactly when the new `ptr_lo` is 0.
- R6: Op code 6 swaps as in R3, then sets `ptr_hi` to `ptr_hi` XOR {0, imm[2:0]}. `imm[3]` is ignored, so `ptr_hi` bit 3 never changes. `zf` becomes 1 exactly when `ptr_hi` was 0 before the operation.
- R7: Op codes 7 and 8 add or subtract 1 to M(ptr) in place, modulo 16. `zf` becomes 1 exactly when the result is 0, and `acc_take` stays 0.
- R8: Op code 9 forces bit imm[1:0] of M(ptr) to 1, and op code 10 forces it to 0. The other bits, `zf` and `acc_take` are unaffected.
- R9: Op code 11 sets `zf` to 1 exactly when `ptr_lo` equals `imm`. It changes neither memory nor the pointer.
- R10: With `op_valid` low, or with an op code of 0 or 12 to 15, memory, pointer, `zf` and `acc_out` keep their values and `acc_take` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see requirements) |
| imm | input | 4 | Immediate: bit select, page modifier or compare value |
| acc_in | input | 4 | Current accumulator value from the core |
| acc_out | output | 4 | Registered nibble for the accumulator |
| acc_take | output | 1 | High for one cycle when `acc_out` holds a new value |
| zf | output | 1 | Registered zero flag |
| ptr_hi | output | 4 | Pointer page part |
| ptr_lo | output | 4 | Pointer offset part |

## Verification
The swap family is exercised at offset 0, at an offset in mid range and at offset 15. This separates correct modulo-16 wrap and the new-offset zero test from an off-by-one flag or a flag computed from the swapped data. Page modification is applied with an immediate whose top bit is set, with page 0 and with a non-zero page, and with a zero modifier. These cases show whether the flag samples the old page and whether the top immediate bit leaks in. In-place arithmetic crosses 15→0 and 0→15. Bit forcing touches the lowest and highest bit positions. Idle cycles and unused codes that carry a conflicting accumulator value are followed by loads, which show that nothing was written.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LOAD    = 4'd1,
    OP_STORE   = 4'd2,
    OP_SWAP    = 4'd3,
    OP_SWAP_UP = 4'd4,
    OP_SWAP_DN = 4'd5,
    OP_SWAP_PG = 4'd6,
    OP_MEM_UP  = 4'd7,
    OP_MEM_DN  = 4'd8,
    OP_BIT_SET = 4'd9,
    OP_BIT_CLR = 4'd10,
    OP_CMP_LO  = 4'd11
  } dpm_op_e;
endpackage

// File: rtl/dpm_nibble_ram.sv
module dpm_nibble_ram #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
  end

  assign rdata = store_q[addr];
endmodule

// File: rtl/dpm_pointer.sv
module dpm_pointer #(
  parameter int HI_W  = 4,
  parameter int LO_W  = 4,
  parameter int MOD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  dpm_pkg::dpm_op_e op,
  input  logic [LO_W-1:0]  imm,
  output logic [HI_W-1:0]  hi_q,
  output logic [LO_W-1:0]  lo_q,
  output logic             flag_upd,
  output logic             flag_val
);
  import dpm_pkg::*;

  logic [HI_W-1:0] hi_n;
  logic [LO_W-1:0] lo_n;
  logic [HI_W-1:0] page_mask;

  assign page_mask = HI_W'(imm[MOD_W-1:0]);

  always_comb begin
    hi_n     = hi_q;
    lo_n     = lo_q;
    flag_upd = 1'b0;
    flag_val = 1'b0;
    if (valid) begin
      unique case (op)
        OP_SWAP_UP: begin
          lo_n     = lo_q + LO_W'(1);
          flag_upd = 1'b1;
          flag_val = (lo_n == '0);
        end
        OP_SWAP_DN: begin
          lo_n     = lo_q - LO_W'(1);
          flag_upd = 1'b1;
          flag_val = (lo_n == '0);
        end
        OP_SWAP_PG: begin
          hi_n     = hi_q ^ page_mask;
          flag_upd = 1'b1;
          flag_val = (hi_q == '0);
        end
        OP_CMP_LO: begin
          flag_upd = 1'b1;
          flag_val = (lo_q == imm);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end
endmodule

// File: rtl/dpm_nibble_ops.sv
module dpm_nibble_ops #(
  parameter int DATA_W = 4,
  parameter int IMM_W  = 4
) (
  input  logic              valid,
  input  dpm_pkg::dpm_op_e  op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] rd,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wd,
  output logic              acc_we,
  output logic              flag_upd,
  output logic              flag_val
);
  import dpm_pkg::*;

  localparam int SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] bit_mask;

  assign bit_mask = DATA_W'(1) << imm[SEL_W-1:0];

  always_comb begin
    mem_we   = 1'b0;
    mem_wd   = rd;
    acc_we   = 1'b0;
    flag_upd = 1'b0;
    flag_val = 1'b0;
    if (valid) begin
      unique case (op)
        OP_LOAD: acc_we = 1'b1;
        OP_STORE: begin
          mem_we = 1'b1;
          mem_wd = acc_in;
        end
        OP_SWAP, OP_SWAP_UP, OP_SWAP_DN, OP_SWAP_PG: begin
          acc_we = 1'b1;
          mem_we = 1'b1;
          mem_wd = acc_in;
        end
        OP_MEM_UP: begin
          mem_we   = 1'b1;
          mem_wd   = rd + DATA_W'(1);
          flag_upd = 1'b1;
          flag_val = (mem_wd == '0);
        end
        OP_MEM_DN: begin
          mem_we   = 1'b1;
          mem_wd   = rd - DATA_W'(1);
          flag_upd = 1'b1;
          flag_val = (mem_wd == '0);
        end
        OP_BIT_SET: begin
          mem_we = 1'b1;
          mem_wd = rd | bit_mask;
        end
        OP_BIT_CLR: begin
          mem_we = 1'b1;
          mem_wd = rd & ~bit_mask;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dpm_unit.sv
module dpm_unit #(
  parameter int DATA_W = 4,
  parameter int HI_W   = 4,
  parameter int LO_W   = 4,
  parameter int MOD_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op,
  input  logic [LO_W-1:0]   imm,
  input  logic [DATA_W-1:0] acc_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_take,
  output logic              zf,
  output logic [HI_W-1:0]   ptr_hi,
  output logic [LO_W-1:0]   ptr_lo
);
  import dpm_pkg::*;

  localparam int ADDR_W = HI_W + LO_W;

  dpm_op_e           op_e;
  logic              ptr_upd, ptr_val;
  logic              dat_upd, dat_val;
  logic              mem_we, acc_we;
  logic [DATA_W-1:0] mem_wd, mem_rd;
  logic [ADDR_W-1:0] addr;

  assign op_e = dpm_op_e'(op);
  assign addr = {ptr_hi, ptr_lo};

  dpm_pointer #(.HI_W(HI_W), .LO_W(LO_W), .MOD_W(MOD_W)) u_ptr (
    .clk(clk), .rst(rst), .valid(op_valid), .op(op_e), .imm(imm),
    .hi_q(ptr_hi), .lo_q(ptr_lo), .flag_upd(ptr_upd), .flag_val(ptr_val)
  );

  dpm_nibble_ops #(.DATA_W(DATA_W), .IMM_W(LO_W)) u_ops (
    .valid(op_valid), .op(op_e), .imm(imm), .acc_in(acc_in), .rd(mem_rd),
    .mem_we(mem_we), .mem_wd(mem_wd), .acc_we(acc_we),
    .flag_upd(dat_upd), .flag_val(dat_val)
  );

  dpm_nibble_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we & ~rst), .addr(addr), .wdata(mem_wd), .rdata(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out  <= '0;
      acc_take <= 1'b0;
      zf       <= 1'b0;
    end else begin
      acc_take <= acc_we;
      if (acc_we) acc_out <= mem_rd;
      if (ptr_upd)      zf <= ptr_val;
      else if (dat_upd) zf <= dat_val;
    end
  end
endmodule

// File: rtl/dpm_unit_chk.sv
module dpm_unit_chk #(
  parameter int DATA_W = 4,
  parameter int HI_W   = 4,
  parameter int LO_W   = 4,
  parameter int MOD_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op,
  input logic [LO_W-1:0]   imm,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] acc_out,
  input logic              acc_take,
  input logic              zf,
  input logic [HI_W-1:0]   ptr_hi,
  input logic [LO_W-1:0]   ptr_lo
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !acc_take && !zf && ptr_hi == '0 && ptr_lo == '0));

  assert_load_takes_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd1) |=> (acc_take && $stable(zf) && $stable(ptr_lo) && $stable(ptr_hi)));

  assert_store_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd2) |=> (!acc_take && $stable(zf) && $stable(acc_out)));

  assert_swap_takes_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd3) |=> (acc_take && $stable(zf) && $stable(ptr_lo) && $stable(ptr_hi)));

  assert_swap_up_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd4) |=>
      (ptr_lo == LO_W'($past(ptr_lo) + LO_W'(1)) && $stable(ptr_hi) && zf == (ptr_lo == '0) && acc_take));

  assert_swap_dn_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd5) |=>
      (ptr_lo == LO_W'($past(ptr_lo) - LO_W'(1)) && $stable(ptr_hi) && zf == (ptr_lo == '0) && acc_take));

  assert_swap_page_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd6) |=>
      (ptr_hi == ($past(ptr_hi) ^ HI_W'($past(imm[MOD_W-1:0]))) && $stable(ptr_lo)
       && zf == ($past(ptr_hi) == '0)));

  assert_page_top_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd6) |=> (ptr_hi[HI_W-1] == $past(ptr_hi[HI_W-1])));

  assert_mem_step_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == 4'd7 || op == 4'd8)) |=> (!acc_take && $stable(ptr_lo) && $stable(ptr_hi)));

  assert_bit_force_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == 4'd9 || op == 4'd10)) |=> (!acc_take && $stable(zf) && $stable(acc_out)));

  assert_cmp_lo_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd11) |=>
      (zf == ($past(ptr_lo) == $past(imm)) && $stable(ptr_lo) && $stable(ptr_hi) && !acc_take));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op == 4'd0 || op >= 4'd12) |=>
      (!acc_take && $stable(zf) && $stable(acc_out) && $stable(ptr_lo) && $stable(ptr_hi)));
endmodule

bind dpm_unit dpm_unit_chk #(.DATA_W(DATA_W), .HI_W(HI_W), .LO_W(LO_W), .MOD_W(MOD_W)) u_chk (.*);

// File: tb/dpm_unit_test.sv
module dpm_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op = 4'd0, imm = 4'd0, acc_in = 4'd0;
  logic [3:0] acc_out, ptr_hi, ptr_lo;
  logic       acc_take, zf;
  int         applied = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  dpm_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .imm(imm), .acc_in(acc_in),
    .acc_out(acc_out), .acc_take(acc_take), .zf(zf), .ptr_hi(ptr_hi), .ptr_lo(ptr_lo)
  );

  // {req, op, imm, acc_in, exp_acc, exp_take, exp_zf, exp_hi, exp_lo}
  localparam int NV = 40;
  localparam logic [29:0] VEC [NV] = '{
    {4'd2,  4'd2,  4'h0, 4'h5, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0}, // R2 store 5 @00
    {4'd2,  4'd1,  4'h0, 4'h0, 4'h5, 1'b1, 1'b0, 4'h0, 4'h0}, // R2 load
    {4'd3,  4'd3,  4'h0, 4'hA, 4'h5, 1'b1, 1'b0, 4'h0, 4'h0}, // R3 swap
    {4'd3,  4'd1,  4'h0, 4'h0, 4'hA, 1'b1, 1'b0, 4'h0, 4'h0}, // R3 swapped value stored
    {4'd4,  4'd4,  4'h0, 4'h3, 4'hA, 1'b1, 1'b0, 4'h0, 4'h1}, // R4 lo 0->1
    {4'd2,  4'd2,  4'h0, 4'h7, 4'hA, 1'b0, 1'b0, 4'h0, 4'h1}, // R2 store @01
    {4'd5,  4'd5,  4'h0, 4'h9, 4'h7, 1'b1, 1'b1, 4'h0, 4'h0}, // R5 lo 1->0, zf
    {4'd4,  4'd1,  4'h0, 4'h0, 4'h3, 1'b1, 1'b1, 4'h0, 4'h0}, // R4 old address written
    {4'd5,  4'd5,  4'h0, 4'h4, 4'h3, 1'b1, 1'b0, 4'h0, 4'hF}, // R5 wrap 0->F
    {4'd2,  4'd2,  4'h0, 4'h2, 4'h3, 1'b0, 1'b0, 4'h0, 4'hF}, // R2 store @0F
    {4'd4,  4'd4,  4'h0, 4'h6, 4'h2, 1'b1, 1'b1, 4'h0, 4'h0}, // R4 wrap F->0, zf
    {4'd6,  4'd6,  4'hF, 4'h8, 4'h4, 1'b1, 1'b1, 4'h7, 4'h0}, // R6 imm3 ignored, old hi 0
    {4'd2,  4'd2,  4'h0, 4'h1, 4'h4, 1'b0, 1'b1, 4'h7, 4'h0}, // R2 store @70
    {4'd6,  4'd6,  4'h2, 4'hC, 4'h1, 1'b1, 1'b0, 4'h5, 4'h0}, // R6 7^2, old hi nonzero
    {4'd2,  4'd2,  4'h0, 4'hF, 4'h1, 1'b0, 1'b0, 4'h5, 4'h0}, // R2 store F @50
    {4'd7,  4'd7,  4'h0, 4'h0, 4'h1, 1'b0, 1'b1, 4'h5, 4'h0}, // R7 F+1=0
    {4'd7,  4'd7,  4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 4'h5, 4'h0}, // R7 0+1
    {4'd7,  4'd8,  4'h0, 4'h0, 4'h1, 1'b0, 1'b1, 4'h5, 4'h0}, // R7 1-1=0
    {4'd7,  4'd8,  4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 4'h5, 4'h0}, // R7 0-1=F
    {4'd7,  4'd1,  4'h0, 4'h0, 4'hF, 1'b1, 1'b0, 4'h5, 4'h0}, // R7 read F
    {4'd2,  4'd2,  4'h0, 4'h0, 4'hF, 1'b0, 1'b0, 4'h5, 4'h0}, // R2 store 0
    {4'd8,  4'd9,  4'h2, 4'h0, 4'hF, 1'b0, 1'b0, 4'h5, 4'h0}, // R8 set bit2
    {4'd8,  4'd9,  4'h0, 4'h0, 4'hF, 1'b0, 1'b0, 4'h5, 4'h0}, // R8 set bit0
    {4'd8,  4'd10, 4'h2, 4'h0, 4'hF, 1'b0, 1'b0, 4'h5, 4'h0}, // R8 clear bit2
    {4'd8,  4'd1,  4'h0, 4'h0, 4'h1, 1'b1, 1'b0, 4'h5, 4'h0}, // R8 read 1
    {4'd8,  4'd10, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 4'h5, 4'h0}, // R8 clear bit0
    {4'd8,  4'd9,  4'h7, 4'h0, 4'h1, 1'b0, 1'b0, 4'h5, 4'h0}, // R8 set bit3 via imm[1:0]
    {4'd8,  4'd1,  4'h0, 4'h0, 4'h8, 1'b1, 1'b0, 4'h5, 4'h0}, // R8 read 8
    {4'd9,  4'd11, 4'h0, 4'h0, 4'h8, 1'b0, 1'b1, 4'h5, 4'h0}, // R9 equal
    {4'd9,  4'd11, 4'h1, 4'h0, 4'h8, 1'b0, 1'b0, 4'h5, 4'h0}, // R9 differ
    {4'd10, 4'd12, 4'h0, 4'hF, 4'h8, 1'b0, 1'b0, 4'h5, 4'h0}, // R10 unused code
    {4'd10, 4'd15, 4'h0, 4'hF, 4'h8, 1'b0, 1'b0, 4'h5, 4'h0}, // R10 unused code
    {4'd10, 4'd1,  4'h0, 4'h0, 4'h8, 1'b1, 1'b0, 4'h5, 4'h0}, // R10 memory intact
    {4'd6,  4'd6,  4'h5, 4'h3, 4'h8, 1'b1, 1'b0, 4'h0, 4'h0}, // R6 5^5=0, zf from old hi
    {4'd6,  4'd1,  4'h0, 4'h0, 4'h8, 1'b1, 1'b0, 4'h0, 4'h0}, // R6 page 0 holds 8
    {4'd9,  4'd11, 4'h0, 4'h0, 4'h8, 1'b1 ^ 1'b1, 1'b1, 4'h0, 4'h0}, // R9 equal again
    {4'd6,  4'd6,  4'h0, 4'hD, 4'h8, 1'b1, 1'b1, 4'h0, 4'h0}, // R6 zero modifier, hi 0
    {4'd3,  4'd1,  4'h0, 4'h0, 4'hD, 1'b1, 1'b1, 4'h0, 4'h0}, // R3 read D
    {4'd4,  4'd4,  4'h0, 4'hE, 4'hD, 1'b1, 1'b0, 4'h0, 4'h1}, // R4 to 01
    {4'd5,  4'd1,  4'h0, 4'h0, 4'h9, 1'b1, 1'b0, 4'h0, 4'h1}  // R5 old address written
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  task automatic check(input int req, input logic [3:0] ea, input logic et,
                       input logic ez, input logic [3:0] eh, input logic [3:0] el);
    applied++;
    if (acc_out !== ea || acc_take !== et || zf !== ez || ptr_hi !== eh || ptr_lo !== el) begin
      miscompares++;
      $display("FAIL R%0d: acc=%h take=%b zf=%b ptr=%h%h expected acc=%h take=%b zf=%b ptr=%h%h",
               req, acc_out, acc_take, zf, ptr_hi, ptr_lo, ea, et, ez, eh, el);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] o, input logic [3:0] i,
                      input logic [3:0] a);
    op_valid = v; op = o; imm = i; acc_in = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0); // R1 reset state
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      step(1'b1, VEC[k][25:22], VEC[k][21:18], VEC[k][17:14]);
      check(int'(VEC[k][29:26]), VEC[k][13:10], VEC[k][9], VEC[k][8], VEC[k][7:4], VEC[k][3:0]);
    end
    // R10: idle store with other data must not write
    step(1'b0, 4'd2, 4'h0, 4'h0);
    check(10, 4'h9, 1'b0, 1'b0, 4'h0, 4'h1);
    step(1'b1, 4'd1, 4'h0, 4'h0);
    check(10, 4'h9, 1'b1, 1'b0, 4'h0, 4'h1);
    // R10: idle pointer walk must not move
    step(1'b0, 4'd4, 4'h0, 4'h3);
    check(10, 4'h9, 1'b0, 1'b0, 4'h0, 4'h1);
    // build non-zero state, then R1 mid-run reset
    step(1'b1, 4'd6, 4'h3, 4'h0);
    check(6, 4'h9, 1'b1, 1'b1, 4'h3, 4'h1);
    rst = 1'b1;
    step(1'b1, 4'd1, 4'h0, 4'h0);
    check(1, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0); // R1 reset wins over op
    rst = 1'b0;
    step(1'b1, 4'd1, 4'h0, 4'h0);
    check(1, 4'hE, 1'b1, 1'b0, 4'h0, 4'h0); // R1 RAM kept over reset
    finish_run();
  end
endmodule